// File: doc/BRIEF.md
# Link-layer ALIGN primitive inserter

This block sits in the transmit path of a serial storage link. It merges ALIGN primitives into the outgoing dword stream so that the far end can compensate for clock skew. An upstream source offers dwords with a valid/ready handshake. The block sends each accepted dword on unchanged. When the rate counter says an ALIGN is due, the block sends the fixed ALIGN word instead and withholds ready from the source for that cycle.

Two rate regimes exist and are chosen by a connection-state input. While no connection is open, the general rate N gives one ALIGN at the start of every window of N output dwords. A value of 0 turns insertion off. While a connection is open, the connected rate M gives two ALIGNs, back to back, at the start of every window of M output dwords. Inserted ALIGNs count toward the window.

Both rates come from one configuration word written through a single-cycle strobe. A write whose connected rate is below 3 is rejected and flagged. An accepted write is held in a shadow copy and takes effect at the next window boundary.

Top module: `align_inserter`

## Requirements
- R1: With the connection flag low and general rate N > 0, the output stream, counted from a window start and with every valid output dword counted including ALIGNs, carries an ALIGN exactly at positions p with p mod N = 0. After T output dwords exactly ceil(T/N) ALIGNs have been sent.
- R2: With the connection flag low and general rate 0, no ALIGN is ever sent and every output dword is upstream data.
- R3: With the connection flag high and connected rate M, the output carries an ALIGN exactly at positions p with p mod M < 2, so the two ALIGNs of a window are consecutive output dwords. During those two cycles in_ready is low.
- R4: A configuration write whose connected-rate field is below 3 raises cfg_err in the cycle after the write and changes neither rate. A write with connected rate 3 or more leaves cfg_err low.
- R5: The general rate is cfg_data[10:0] and the connected rate is cfg_data[23:16]. All other bits of cfg_data have no effect.
- R6: While rst is high, out_valid, out_prim and cfg_err are low. After reset the general rate is 127 and the connected rate is 255, and the first window starts with the first output after reset.
- R7: A change of conn_open gives one cycle with no output and in_ready low. The next output is the start of a fresh window of the new regime, using the latest accepted rates.
- R8: An accepted write made in the middle of a window does not change that window. The new rate applies from the next window boundary.
- R9: out_prim is high only on inserted ALIGNs, whose out_data is 32'hBC4A4A7B. Data dwords appear in the cycle after their handshake, unchanged, in order, with none dropped or repeated.
- R10: ALIGNs that are due are sent even when the upstream source is idle. A cycle with neither a due ALIGN nor upstream data has out_valid low and does not advance the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 32 | Configuration word (general rate [10:0], connected rate [23:16]) |
| cfg_err | output | 1 | Pulses high the cycle after a rejected write |
| conn_open | input | 1 | High while a connection is open |
| in_data | input | 32 | Upstream dword |
| in_valid | input | 1 | Upstream dword offered |
| in_ready | output | 1 | Block accepts the upstream dword this cycle |
| out_data | output | 32 | Transmitted dword |
| out_valid | output | 1 | out_data holds a dword to transmit |
| out_prim | output | 1 | out_data is an inserted ALIGN |

## Verification
The bench builds the block with its default widths (an 11-bit general rate and an 8-bit connected rate), so the reset rates 127 and 255 run in full next to a sweep of every general rate from 0 to 20 and every connected rate from 3 to 20. Each run starts from a regime restart. Each output dword is then checked against its position modulo the rate, and the ALIGN total is checked against a closed-form count. A gapped upstream pattern on part of the sweep brings idle cycles and stalled windows within reach. Mid-window writes, rejected writes and words with the ignored bits set reach the boundary and field rules.

// File: rtl/align_pkg.sv
package align_pkg;

  typedef enum logic {
    MODE_GEN  = 1'b0,
    MODE_CONN = 1'b1
  } mode_e;

  function automatic int max_w(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/align_cfg.sv
module align_cfg #(
  parameter int DW      = 32,
  parameter int GEN_W   = 11,
  parameter int CON_W   = 8,
  parameter int GEN_LSB = 0,
  parameter int CON_LSB = 16,
  parameter int CON_MIN = 3,
  parameter logic [GEN_W-1:0] GEN_RST = GEN_W'(127),
  parameter logic [CON_W-1:0] CON_RST = CON_W'(255)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [DW-1:0]    cfg_data,
  output logic [GEN_W-1:0] sh_gen,
  output logic [CON_W-1:0] sh_con,
  output logic             cfg_err
);

  logic [GEN_W-1:0] wr_gen;
  logic [CON_W-1:0] wr_con;
  logic             wr_bad;
  logic             cfg_unused;

  assign wr_gen     = cfg_data[GEN_LSB +: GEN_W];
  assign wr_con     = cfg_data[CON_LSB +: CON_W];
  assign wr_bad     = (wr_con < CON_W'(CON_MIN));
  assign cfg_unused = ^cfg_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_gen  <= GEN_RST;
      sh_con  <= CON_RST;
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= cfg_wr && wr_bad;
      if (cfg_wr && !wr_bad) begin
        sh_gen <= wr_gen;
        sh_con <= wr_con;
      end
    end
  end

  // R4
  reject_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && wr_bad) |=> (cfg_err && $stable(sh_gen) && $stable(sh_con)));

  // R4
  con_floor_chk: assert property (@(posedge clk) disable iff (rst)
    sh_con >= CON_W'(CON_MIN));

endmodule

// File: rtl/align_window.sv
module align_window
  import align_pkg::*;
#(
  parameter int GEN_W = 11,
  parameter int CON_W = 8,
  parameter int CNT_W = 11,
  parameter logic [GEN_W-1:0] GEN_RST = GEN_W'(127),
  parameter logic [CON_W-1:0] CON_RST = CON_W'(255)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conn_open,
  input  logic [GEN_W-1:0] sh_gen,
  input  logic [CON_W-1:0] sh_con,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             emit_align,
  output logic             emit_data
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  mode_e            act_mode;
  mode_e            want_mode;
  logic [GEN_W-1:0] act_gen;
  logic [CON_W-1:0] act_con;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] rate_w;
  logic             restart;
  logic             due;
  logic             step;
  logic             wrap;

  assign want_mode = conn_open ? MODE_CONN : MODE_GEN;
  assign restart   = (want_mode != act_mode);
  assign rate_w    = (act_mode == MODE_CONN) ? CNT_W'(act_con) : CNT_W'(act_gen);

  always_comb begin
    if (act_mode == MODE_CONN) due = (cnt < TWO);
    else                       due = (act_gen != '0) && (cnt == '0);
  end

  assign emit_align = !restart && due;
  assign in_ready   = !restart && !due;
  assign emit_data  = in_ready && in_valid;
  assign step       = emit_align || emit_data;
  assign wrap       = step && (cnt == rate_w - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_mode <= MODE_GEN;
      act_gen  <= GEN_RST;
      act_con  <= CON_RST;
      cnt      <= '0;
    end else if (restart) begin
      act_mode <= want_mode;
      act_gen  <= sh_gen;
      act_con  <= sh_con;
      cnt      <= '0;
    end else if (rate_w == '0) begin
      act_gen  <= sh_gen;
      act_con  <= sh_con;
      cnt      <= '0;
    end else if (wrap) begin
      act_gen  <= sh_gen;
      act_con  <= sh_con;
      cnt      <= '0;
    end else if (step) begin
      cnt      <= cnt + ONE;
    end
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_w != '0) |-> (cnt < rate_w));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0));

  // R3
  pair_chk: assert property (@(posedge clk) disable iff (rst)
    (emit_align && act_mode == MODE_CONN && cnt == '0) |=> (emit_align || restart));

endmodule

// File: rtl/align_mux.sv
module align_mux #(
  parameter int DW = 32,
  parameter logic [DW-1:0] ALIGN_WORD = 32'hBC4A_4A7B
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          emit_align,
  input  logic          emit_data,
  input  logic [DW-1:0] in_data,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          out_prim
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      out_prim  <= 1'b0;
    end else begin
      out_valid <= emit_align || emit_data;
      out_prim  <= emit_align;
      if (emit_align)     out_data <= ALIGN_WORD;
      else if (emit_data) out_data <= in_data;
    end
  end

  // R9
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({emit_align, emit_data}));

  // R9
  pass_chk: assert property (@(posedge clk) disable iff (rst)
    emit_data |=> (out_valid && !out_prim && out_data == $past(in_data)));

  // R9
  prim_word_chk: assert property (@(posedge clk) disable iff (rst)
    out_prim |-> (out_valid && out_data == ALIGN_WORD));

endmodule

// File: rtl/align_inserter.sv
module align_inserter #(
  parameter int DW      = 32,
  parameter int GEN_W   = 11,
  parameter int CON_W   = 8,
  parameter int GEN_LSB = 0,
  parameter int CON_LSB = 16,
  parameter int CON_MIN = 3,
  parameter logic [GEN_W-1:0] GEN_RST = GEN_W'(127),
  parameter logic [CON_W-1:0] CON_RST = CON_W'(255),
  parameter logic [DW-1:0]    ALIGN_WORD = 32'hBC4A_4A7B
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [DW-1:0] cfg_data,
  output logic          cfg_err,
  input  logic          conn_open,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          out_prim
);

  localparam int CNT_W = align_pkg::max_w(GEN_W, CON_W);

  logic [GEN_W-1:0] sh_gen;
  logic [CON_W-1:0] sh_con;
  logic             emit_align;
  logic             emit_data;

  align_cfg #(
    .DW(DW), .GEN_W(GEN_W), .CON_W(CON_W), .GEN_LSB(GEN_LSB),
    .CON_LSB(CON_LSB), .CON_MIN(CON_MIN), .GEN_RST(GEN_RST), .CON_RST(CON_RST)
  ) cfg_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .sh_gen(sh_gen), .sh_con(sh_con), .cfg_err(cfg_err)
  );

  align_window #(
    .GEN_W(GEN_W), .CON_W(CON_W), .CNT_W(CNT_W),
    .GEN_RST(GEN_RST), .CON_RST(CON_RST)
  ) win_i (
    .clk(clk), .rst(rst), .conn_open(conn_open), .sh_gen(sh_gen), .sh_con(sh_con),
    .in_valid(in_valid), .in_ready(in_ready),
    .emit_align(emit_align), .emit_data(emit_data)
  );

  align_mux #(
    .DW(DW), .ALIGN_WORD(ALIGN_WORD)
  ) mux_i (
    .clk(clk), .rst(rst), .emit_align(emit_align), .emit_data(emit_data),
    .in_data(in_data), .out_data(out_data), .out_valid(out_valid), .out_prim(out_prim)
  );

endmodule

// File: tb/align_inserter_tb.sv
module align_inserter_tb_top;

  localparam logic [31:0] ALIGN = 32'hBC4A_4A7B;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_data = '0;
  logic        cfg_err;
  logic        conn_open = 1'b0;
  logic [31:0] in_data;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] out_data;
  logic        out_valid;
  logic        out_prim;

  always #2 clk = ~clk;

  align_inserter dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data), .cfg_err(cfg_err),
    .conn_open(conn_open), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_prim(out_prim)
  );

  int n_total = 0;
  int n_fail  = 0;

  // source
  logic [31:0] src_data = 32'd1;
  logic        acc = 1'b0;
  logic        want_valid = 1'b0;
  logic        gapped = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  assign in_data = src_data;

  always begin
    @(posedge clk);
    #1;
    if (acc) src_data <= src_data + 32'd1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    in_valid <= want_valid && (!gapped || lfsr[0] || lfsr[3]);
  end

  // monitor
  logic        m_on = 1'b0;
  logic        m_conn = 1'b0;
  int          m_rate = 0;
  int          m_pos = 0;
  int          m_outs = 0;
  int          m_prims = 0;
  int          m_err = 0;
  int          m_bad_pos = 0;
  logic        m_bad_act = 1'b0;
  logic        pend_on = 1'b0;
  int          pend_rate = 0;
  logic [31:0] prev_data = '0;
  logic        have_prev = 1'b0;
  int          data_err = 0;
  logic [31:0] data_bad_act = '0;
  logic [31:0] data_bad_exp = '0;

  always @(negedge clk) begin
    acc = in_valid && in_ready;
    if (!rst && out_valid) begin
      if (out_prim && out_data != ALIGN) begin
        data_err++; data_bad_act = out_data; data_bad_exp = ALIGN;
      end
      if (!out_prim) begin
        if (have_prev && out_data != prev_data + 32'd1) begin
          data_err++; data_bad_act = out_data; data_bad_exp = prev_data + 32'd1;
        end
        prev_data = out_data;
        have_prev = 1'b1;
      end
      if (m_on) begin
        logic exp_p;
        if (pend_on && m_rate != 0 && m_pos != 0 && (m_pos % m_rate) == 0) begin
          m_rate = pend_rate; m_pos = 0; pend_on = 1'b0;
        end
        if (m_conn) exp_p = ((m_pos % m_rate) < 2);
        else        exp_p = (m_rate != 0) && ((m_pos % m_rate) == 0);
        if (out_prim != exp_p) begin
          if (m_err == 0) begin m_bad_pos = m_pos; m_bad_act = out_prim; end
          m_err++;
        end
        m_outs++;
        if (out_prim) m_prims++;
        m_pos++;
      end
    end
  end

  task automatic check(input string tag, input bit ok, input int act, input int exp_v);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(input logic [31:0] v, output logic err);
    tick();
    cfg_wr = 1'b1; cfg_data = v;
    tick();
    cfg_wr = 1'b0;
    err = cfg_err;
  endtask

  task automatic start_count(input logic conn, input int rate);
    m_on = 1'b1; m_conn = conn; m_rate = rate; m_pos = 0;
    m_outs = 0; m_prims = 0; m_err = 0; pend_on = 1'b0;
  endtask

  task automatic run_outs(input int n);
    want_valid = 1'b1;
    while (m_outs < n) tick();
    want_valid = 1'b0;
    repeat (8) tick();
  endtask

  function automatic int exp_prims(input logic conn, input int rate, input int outs);
    if (conn) return (outs / rate) * 2 + (((outs % rate) < 2) ? (outs % rate) : 2);
    if (rate == 0) return 0;
    return (outs + rate - 1) / rate;
  endfunction

  task automatic end_check(input string tag);
    int e;
    e = exp_prims(m_conn, m_rate, m_outs);
    check({tag, " ALIGN placement"}, m_err == 0, int'(m_bad_act), m_bad_pos);
    check({tag, " ALIGN count"}, m_prims == e, m_prims, e);
  endtask

  // leave conn mode stalled, restart into general mode with rate n
  task automatic into_gen(input int n);
    tick();
    start_count(1'b0, n);
    conn_open = 1'b0;
  endtask

  task automatic into_conn(input int m);
    tick();
    start_count(1'b1, m);
    conn_open = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    n_total++; n_fail++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic err;
    repeat (5) tick();
    // R6 reset state
    check("R6 reset out_valid", out_valid == 1'b0, int'(out_valid), 0);
    check("R6 reset out_prim", out_prim == 1'b0, int'(out_prim), 0);
    check("R6 reset cfg_err", cfg_err == 1'b0, int'(cfg_err), 0);
    start_count(1'b0, 127);
    rst = 1'b0;
    run_outs(300);
    end_check("R6 default general 127");
    into_conn(255);
    run_outs(600);
    end_check("R6 default connected 255");

    // R10 / R7: idle restarts still send due ALIGNs, then stall
    into_gen(127);
    repeat (10) tick();
    check("R10 idle general outputs", m_outs == 1 && m_prims == 1, m_outs * 10 + m_prims, 11);
    into_conn(255);
    repeat (10) tick();
    check("R7 idle connected restart pair", m_outs == 2 && m_prims == 2, m_outs * 10 + m_prims, 22);

    // R1 / R2 sweep of general rates
    for (int n = 0; n <= 20; n++) begin
      cfg_write({8'h00, 8'd5, 5'd0, 11'(n)}, err);
      repeat (3) tick();
      gapped = (n >= 10);
      into_gen(n);
      run_outs(4 * n + 7);
      end_check((n == 0) ? "R2 general rate 0" : "R1 general sweep");
      conn_open = 1'b1;
      repeat (8) tick();
    end

    // R3 sweep of connected rates
    for (int m = 3; m <= 20; m++) begin
      cfg_write({8'h00, 8'(m), 5'd0, 11'd5}, err);
      conn_open = 1'b0;
      repeat (10) tick();
      gapped = (m % 2 == 0);
      into_conn(m);
      run_outs(4 * m + 5);
      end_check("R3 connected sweep");
    end
    gapped = 1'b0;

    // R4 validation
    cfg_write({8'h00, 8'd3, 5'd0, 11'd9}, err);
    check("R4 minimum connected rate accepted", err == 1'b0, int'(err), 0);
    cfg_write({8'h00, 8'd2, 5'd0, 11'd11}, err);
    check("R4 connected rate 2 flagged", err == 1'b1, int'(err), 1);
    tick();
    check("R4 flag is one pulse", cfg_err == 1'b0, int'(cfg_err), 0);
    into_gen(9);
    run_outs(40);
    end_check("R4 rejected write kept general");
    into_conn(3);
    run_outs(20);
    end_check("R4 rejected write kept connected");

    // R5 field positions, foreign bits set
    cfg_write(32'hFF07_F806, err);
    check("R5 foreign bits not flagged", err == 1'b0, int'(err), 0);
    into_gen(6);
    run_outs(30);
    end_check("R5 general field");
    into_conn(7);
    run_outs(30);
    end_check("R5 connected field");

    // R8 mid-window write applies at next boundary
    cfg_write({8'h00, 8'd5, 5'd0, 11'd4}, err);
    into_gen(4);
    run_outs(6);
    cfg_write({8'h00, 8'd5, 5'd0, 11'd9}, err);
    pend_on = 1'b1; pend_rate = 9;
    run_outs(40);
    check("R8 new rate at boundary", m_err == 0 && pend_on == 1'b0, m_err, 0);

    // R9 data integrity over the whole run
    check("R9 data order and ALIGN word", data_err == 0, int'(data_bad_act), int'(data_bad_exp));
    check("R9 data seen", have_prev == 1'b1, int'(have_prev), 1);

    summary();
    $finish;
  end

endmodule